// File: doc/BRIEF.md
# Alert-Driven Bank Masking Command Gate

This block sits on the controller side of a DRAM rank. It sits between the command scheduler and the rank, on the scheduler's command stream. When the rank raises its alert line, the gate waits out a fixed hold-off window while the command stream keeps passing. It then issues one mask-refresh command and takes in the per-bank alert vector that the rank returns. After that it holds back every command aimed at a flagged bank, and commands to all other banks keep flowing.

The command stream uses a valid/ready handshake and carries a bank index and an opaque payload. A command to a flagged bank that reaches the head of the stream drops the upstream ready, so the stream stalls and no command is dropped or reordered. The captured vector stays in force until the controller signals that the mitigation is complete. An alert that arrives in the middle of a sequence is remembered and starts a new sequence once the gate is back in idle.

The hold-off length is a cycle count derived from two parameters: the clock period and the window length, both in picoseconds. It is the window divided by the period, rounded up. The defaults give 180 ns at 8 ns per cycle, which is 23 cycles.

Top module: `bank_mask_gate`

## Requirements
- R1: While idle, a high `alert_i` sampled on a clock edge starts a mitigation sequence. `rfm_o` never rises unless an alert has started a sequence.
- R2: The hold-off lasts exactly HOLD_CYC cycles, which is 23 with the default parameters. `rfm_o` is high in cycle HOLD_CYC+1, counting the cycle after the edge that sampled the alert as cycle 1.
- R3: Each sequence raises `rfm_o` for exactly one cycle.
- R4: The first `vec_valid_i` after the mask-refresh issue loads `vec_i`. Bit i belongs to bank i: a 1 means alerted and a 0 means clear. `vec_valid_i` has no effect at any other time.
- R5: While the mask is in force, a command whose bank bit is 1 holds `out_valid` at 0 and `in_ready` at 0 for as long as it stays at the head.
- R6: A command that is not blocked passes unchanged. `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and bank and payload are copied through, so nothing is dropped or reordered.
- R7: During the hold-off, and up to the capture of the vector, commands pass unfiltered.
- R8: The mask stays in force until `done_i` is sampled high. At that edge the mask is lifted and the gate returns to idle.
- R9: An alert sampled while a sequence is in progress is latched. It starts a new sequence on the cycle after the return to idle.
- R10: After reset the gate is idle, `rfm_o` is 0, and no bank is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alert_i | input | 1 | Alert from the rank (pulse or level) |
| rfm_o | output | 1 | One-cycle mask-refresh command issue |
| vec_valid_i | input | 1 | Alert vector from the rank is present |
| vec_i | input | NUM_BANKS | Per-bank alert vector, bit i = bank i |
| done_i | input | 1 | Mitigation complete, lift the mask |
| in_valid | input | 1 | Upstream command valid |
| in_ready | output | 1 | Upstream command accepted |
| in_bank | input | BANK_W | Bank index of upstream command |
| in_payload | input | PAYLOAD_W | Opaque command bits |
| out_valid | output | 1 | Downstream command valid |
| out_ready | input | 1 | Downstream accepts command |
| out_bank | output | BANK_W | Bank index toward the rank |
| out_payload | output | PAYLOAD_W | Command bits toward the rank |

## Verification
The assertions assume that the stream inputs follow valid/ready rules. They also assume that `in_bank` always names a bank below NUM_BANKS, which holds because NUM_BANKS is a power of two. The bench drives every input at the falling edge and moves on to the next command only after a handshake or a deliberate stall. It raises `vec_valid_i` and `done_i` as single-cycle pulses, including one pulse outside the capture window, so that ignoring it can be seen at the stream outputs. Alert pulses are placed both in idle and in the middle of the mask phase, which covers the fresh-start path and the latched-restart path.

// File: rtl/bmg_pkg.sv
// Package: shared state encoding for the bank mask gate.
// Assumes: none.
package bmg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HOLD  = 3'd1,
        ST_ISSUE = 3'd2,
        ST_WAITV = 3'd3,
        ST_MASK  = 3'd4
    } gate_state_t;
endpackage

// File: rtl/bmg_holdoff.sv
// Module: one-shot hold-off timer.
// On start_i it counts CYC cycles and raises expire_o in the last one.
// Assumes: start_i is only raised while the timer is not running; CYC >= 1.
module bmg_holdoff #(
    parameter int CYC = 23
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic expire_o
);
    localparam int CW = $clog2(CYC + 1);

    logic          run;
    logic [CW-1:0] cnt;

    // Expiry in the final counted cycle.
    assign expire_o = run && (cnt == CW'(CYC - 1));

    // Run flag and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start_i) begin
            run <= 1'b1;
            cnt <= '0;
        end else if (expire_o) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end
    end

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < CW'(CYC)));
    assert_expire_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_o && !start_i) |=> !run);
endmodule

// File: rtl/bmg_sequencer.sv
// Module: mitigation sequencer.
// Steps through idle, hold-off, mask-refresh issue, vector wait and mask phase.
// It latches alerts that arrive mid-sequence and owns the captured bank mask.
// Assumes: vec_valid_i and done_i are single-cycle pulses from the rank side.
module bmg_sequencer
    import bmg_pkg::*;
#(
    parameter int NB       = 8,
    parameter int HOLD_CYC = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alert_i,
    input  logic          vec_valid_i,
    input  logic [NB-1:0] vec_i,
    input  logic          done_i,
    output logic          rfm_o,
    output logic          mask_act_o,
    output logic [NB-1:0] mask_o
);
    gate_state_t   state;
    logic          pend;
    logic          trig;
    logic          start;
    logic          expire;
    logic [NB-1:0] mask_q;

    bmg_holdoff #(.CYC(HOLD_CYC)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .expire_o (expire)
    );

    // A new or remembered alert starts a sequence from idle.
    assign trig  = alert_i || pend;
    assign start = (state == ST_IDLE) && trig;

    // Main sequence state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (trig) state <= ST_HOLD;
                ST_HOLD:  if (expire) state <= ST_ISSUE;
                ST_ISSUE: state <= ST_WAITV;
                ST_WAITV: if (vec_valid_i) state <= ST_MASK;
                ST_MASK:  if (done_i) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Remember alerts seen outside idle; consumed by the next start.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pend <= 1'b0;
        else if (state != ST_IDLE)  pend <= pend || alert_i;
        else if (start)             pend <= 1'b0;
    end

    // Capture the bank vector once per sequence; drop it on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                                mask_q <= '0;
        else if (state == ST_WAITV && vec_valid_i) mask_q <= vec_i;
        else if (state == ST_MASK && done_i)       mask_q <= '0;
    end

    assign rfm_o      = (state == ST_ISSUE);
    assign mask_act_o = (state == ST_MASK);
    assign mask_o     = mask_q;

    assert_single_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rfm_o |=> !rfm_o);
    assert_issue_after_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rfm_o) |-> $past(expire));
    assert_mask_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_act_o && !done_i) |=> (mask_act_o && $stable(mask_q)));
    assert_pending_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pend) |=> (state == ST_HOLD));
endmodule

// File: rtl/bmg_filter.sv
// Module: command stream gate.
// Blocks the head command when the mask is in force and its bank bit is set.
// Any other command passes straight through.
// Assumes: NB is a power of two, so every bank index is in range.
module bmg_filter #(
    parameter int NB = 8,
    parameter int PW = 16,
    localparam int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_act_i,
    input  logic [NB-1:0] mask_i,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [BW-1:0] in_bank,
    input  logic [PW-1:0] in_payload,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [BW-1:0] out_bank,
    output logic [PW-1:0] out_payload
);
    logic hit;

    // Head command targets a flagged bank while the mask is in force.
    assign hit = mask_act_i && mask_i[in_bank];

    assign out_valid   = in_valid && !hit;
    assign in_ready    = out_ready && !hit;
    assign out_bank    = in_bank;
    assign out_payload = in_payload;

    assert_blocked_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_act_i && in_valid && mask_i[in_bank]) |-> (!out_valid && !in_ready));
    assert_no_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (out_valid && out_ready && out_bank == in_bank));
    assert_open_when_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_act_i |-> (out_valid == in_valid && in_ready == out_ready));
endmodule

// File: rtl/bank_mask_gate.sv
// Module: top of the alert-driven bank masking command gate.
// Joins the sequencer (alert, hold-off, mask-refresh, vector capture) with the stream gate.
// Assumes: NUM_BANKS is a power of two; HOLDOFF_PS and CLK_PERIOD_PS are positive.
module bank_mask_gate #(
    parameter int NUM_BANKS     = 8,
    parameter int PAYLOAD_W     = 16,
    parameter int CLK_PERIOD_PS = 8000,
    parameter int HOLDOFF_PS    = 180000,
    localparam int BANK_W       = $clog2(NUM_BANKS),
    localparam int HOLD_CYC     = (HOLDOFF_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alert_i,
    output logic                 rfm_o,
    input  logic                 vec_valid_i,
    input  logic [NUM_BANKS-1:0] vec_i,
    input  logic                 done_i,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [BANK_W-1:0]    in_bank,
    input  logic [PAYLOAD_W-1:0] in_payload,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [BANK_W-1:0]    out_bank,
    output logic [PAYLOAD_W-1:0] out_payload
);
    logic                 mask_act;
    logic [NUM_BANKS-1:0] mask;

    bmg_sequencer #(.NB(NUM_BANKS), .HOLD_CYC(HOLD_CYC)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .alert_i     (alert_i),
        .vec_valid_i (vec_valid_i),
        .vec_i       (vec_i),
        .done_i      (done_i),
        .rfm_o       (rfm_o),
        .mask_act_o  (mask_act),
        .mask_o      (mask)
    );

    bmg_filter #(.NB(NUM_BANKS), .PW(PAYLOAD_W)) u_filt (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_act_i  (mask_act),
        .mask_i      (mask),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_bank     (in_bank),
        .in_payload  (in_payload),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_bank    (out_bank),
        .out_payload (out_payload)
    );

    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |=> (!rfm_o && !mask_act));
    assert_issue_needs_alert_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rfm_o |-> !mask_act);
endmodule

// File: tb/tb_bank_mask_gate.sv
module tb_bank_mask_gate;
    localparam int NB   = 8;
    localparam int BW   = 3;
    localparam int PW   = 16;
    localparam int HOLD = 23;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          alert_i, rfm_o, vec_valid_i, done_i;
    logic [NB-1:0] vec_i;
    logic          in_valid, in_ready, out_valid, out_ready;
    logic [BW-1:0] in_bank, out_bank;
    logic [PW-1:0] in_payload, out_payload;

    int n_chk  = 0;
    int n_fail = 0;
    int rfm_pulses = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bank_mask_gate dut (
        .clk(clk), .rst_n(rst_n), .alert_i(alert_i), .rfm_o(rfm_o),
        .vec_valid_i(vec_valid_i), .vec_i(vec_i), .done_i(done_i),
        .in_valid(in_valid), .in_ready(in_ready), .in_bank(in_bank),
        .in_payload(in_payload), .out_valid(out_valid), .out_ready(out_ready),
        .out_bank(out_bank), .out_payload(out_payload)
    );

    // stimulus table: {out_ready, bank[2:0]}
    localparam logic [3:0] STIM [12] = '{
        4'b1000, 4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1101,
        4'b1110, 4'b1111, 4'b0010, 4'b0011, 4'b0101, 4'b1101
    };

    always @(posedge clk) if (rst_n && rfm_o) rfm_pulses <= rfm_pulses + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // Apply one stream vector under model mask m (m_act = mask in force).
    task automatic apply(input logic [3:0] v, input logic [NB-1:0] m, input bit m_act,
                         input int tag, input string req);
        bit blk;
        @(negedge clk);
        in_valid = 1'b1; in_bank = v[2:0]; out_ready = v[3]; in_payload = PW'(tag);
        #1;
        blk = m_act && m[v[2:0]];
        check(out_valid == !blk, req, int'(out_valid), int'(!blk));
        check(in_ready == (v[3] && !blk), req, int'(in_ready), int'(v[3] && !blk));
        if (!blk) check(out_bank == v[2:0] && out_payload == PW'(tag), "R6",
                        int'(out_payload), tag);
    endtask

    task automatic pulse_alert();
        @(negedge clk); alert_i = 1'b1;
        @(negedge clk); alert_i = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

    initial begin
        int zeros;
        int base;
        rst_n = 1'b0; alert_i = 0; vec_valid_i = 0; vec_i = '0; done_i = 0;
        in_valid = 0; in_bank = '0; in_payload = '0; out_ready = 1;
        repeat (3) @(negedge clk);
        #1;
        check(rfm_o == 1'b0, "R10", int'(rfm_o), 0);
        rst_n = 1'b1;
        // R10: no mask after reset, every bank passes
        for (int i = 0; i < 8; i++) apply(STIM[i], 8'h00, 1'b0, i, "R10");

        // R4: vector pulse in idle is ignored
        @(negedge clk); vec_valid_i = 1; vec_i = 8'hFF;
        @(negedge clk); vec_valid_i = 0; vec_i = '0;
        repeat (5) @(negedge clk);
        check(rfm_pulses == 0, "R1", rfm_pulses, 0);
        for (int i = 0; i < 8; i++) apply(STIM[i], 8'h00, 1'b0, 20 + i, "R4");

        // R1/R2/R7: start sequence, count hold-off, stream stays open
        @(negedge clk); alert_i = 1'b1;
        @(negedge clk); alert_i = 1'b0; #1;
        zeros = 0;
        while (!rfm_o && zeros < 100) begin
            check(out_valid == in_valid && in_ready == out_ready, "R7",
                  int'(out_valid), int'(in_valid));
            zeros++;
            @(negedge clk);
            in_valid = 1'b1; in_bank = BW'(zeros); out_ready = 1'b1;
            #1;
        end
        check(zeros == HOLD, "R2", zeros, HOLD);
        check(rfm_o == 1'b1, "R1", int'(rfm_o), 1);
        @(negedge clk); #1;
        check(rfm_o == 1'b0, "R3", int'(rfm_o), 0);
        // R7: waiting for vector, still unfiltered
        for (int i = 0; i < 4; i++) apply(STIM[i], 8'h24, 1'b0, 40 + i, "R7");
        @(negedge clk); vec_valid_i = 1; vec_i = 8'h24;
        @(negedge clk); vec_valid_i = 0; vec_i = '0;

        // R5/R6: table walk under mask 0x24
        for (int i = 0; i < 12; i++) apply(STIM[i], 8'h24, 1'b1, 60 + i, "R5");
        // R5: stalled head stays blocked
        for (int i = 0; i < 6; i++) apply(4'b1010, 8'h24, 1'b1, 80, "R5");
        // R8: mask still in force after idle cycles
        @(negedge clk); in_valid = 0;
        repeat (10) @(negedge clk);
        apply(4'b1101, 8'h24, 1'b1, 90, "R8");
        check(rfm_pulses == 1, "R3", rfm_pulses, 1);

        // R9: alert during mask phase is latched
        pulse_alert();
        apply(4'b1010, 8'h24, 1'b1, 91, "R9");
        @(negedge clk); done_i = 1'b1;
        @(negedge clk); done_i = 1'b0;
        // R8: mask lifted after done
        apply(4'b1010, 8'h00, 1'b0, 92, "R8");
        apply(4'b1101, 8'h00, 1'b0, 93, "R8");
        // the latched alert restarts: rfm within hold-off window
        base = 0;
        #1;
        while (!rfm_o && base < 100) begin @(negedge clk); #1; base++; end
        check(rfm_o == 1'b1 && base <= HOLD, "R9", base, HOLD);
        @(negedge clk); vec_valid_i = 1; vec_i = 8'h01;
        @(negedge clk); vec_valid_i = 0; vec_i = '0;
        apply(4'b1000, 8'h01, 1'b1, 100, "R5");
        apply(4'b1001, 8'h01, 1'b1, 101, "R6");
        @(negedge clk); in_valid = 0; done_i = 1'b1;
        @(negedge clk); done_i = 1'b0;
        repeat (40) @(negedge clk);
        check(rfm_pulses == 2, "R3", rfm_pulses, 2);
        apply(4'b1000, 8'h00, 1'b0, 102, "R8");
        finish_run();
    end
endmodule